// File: doc/BRIEF.md
# Synchronous-Reset Register with Selectable Reset/Enable Priority

This block is a parameterized edge-triggered register with a clock enable and a synchronous reset whose value is a fixed parameter. One parameter decides how the two controls interact. In reset-first mode an active reset loads the reset value on every active edge, whatever the enable does. In enable-first mode the reset is only honoured on edges where the enable is also active; otherwise the register keeps its contents.

The capturing clock edge, the sense of the reset pin and the sense of the enable pin are each set by a parameter. The block can therefore be dropped in wherever a netlist-level or hand-written register with any of these conventions is needed, without inverters at the call site. There is no asynchronous reset, no asynchronous load and no transparent latch behaviour.

Top module: `sreg_prio`

## Requirements
- R1: Q changes only on the active clock edge: the rising edge when CLK_POL is 1, the falling edge when CLK_POL is 0; the opposite edge leaves Q unchanged.
- R2: With the reset inactive and the enable active, Q takes D on the active edge.
- R3: With both the reset and the enable inactive, Q keeps its value across the active edge.
- R4: With PRIO set to reset-first, an active reset loads RST_VALUE on the active edge even while the enable is inactive.
- R5: With both the reset and the enable active, Q becomes RST_VALUE on the active edge in either priority mode.
- R6: With PRIO set to enable-first, an active reset with an inactive enable leaves Q unchanged.
- R7: RST_POL of 1 makes the reset active when the pin is 1; RST_POL of 0 makes it active when the pin is 0.
- R8: EN_POL of 1 makes the enable active when the pin is 1; EN_POL of 0 makes it active when the pin is 0.
- R9: The value loaded by reset is the constant RST_VALUE, independent of D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capturing edge chosen by CLK_POL |
| d | input | WIDTH | Data captured when enabled and not reset |
| srst | input | 1 | Synchronous reset, sense chosen by RST_POL |
| en | input | 1 | Clock enable, sense chosen by EN_POL |
| q | output | WIDTH | Register contents |

## Verification
The bench sweeps every data value of a four-bit instance through all four reset/enable combinations, once on a rising-edge, active-high, reset-first instance and once on a falling-edge, active-low, enable-first instance. The sharp case is reset with enable inactive: a design that ignored the priority setting would either clear the enable-first register when it should hold, or fail to clear the reset-first one. Each step also samples Q just after the opposite clock edge, which catches a register wired to the wrong edge, and an inverted-sense error shows up as loads and resets appearing on exactly the wrong combinations. Data values equal to and different from RST_VALUE show whether the reset path loads the constant or leaks D.

// File: rtl/sreg_prio_pkg.sv
package sreg_prio_pkg;

  // Which control wins when reset is asserted with the enable off.
  typedef enum logic {
    PRIO_RST_FIRST = 1'b0,
    PRIO_EN_FIRST  = 1'b1
  } prio_e;

  // Controls after polarity normalisation (1 = active).
  typedef struct packed {
    logic rst;
    logic en;
  } ctl_s;

endpackage

// File: rtl/sreg_prio_ctl.sv
module sreg_prio_ctl
  import sreg_prio_pkg::*;
#(
  parameter bit RST_POL = 1'b1,
  parameter bit EN_POL  = 1'b1
) (
  input  logic srst_pin,
  input  logic en_pin,
  output ctl_s ctl
);

  logic rst_act;
  logic en_act;

  generate
    if (RST_POL) begin : g_rst_high
      assign rst_act = srst_pin;
    end else begin : g_rst_low
      assign rst_act = ~srst_pin;
    end

    if (EN_POL) begin : g_en_high
      assign en_act = en_pin;
    end else begin : g_en_low
      assign en_act = ~en_pin;
    end
  endgenerate

  assign ctl.rst = rst_act;
  assign ctl.en  = en_act;

endmodule

// File: rtl/sreg_prio_next.sv
module sreg_prio_next
  import sreg_prio_pkg::*;
#(
  parameter int                WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RST_VALUE = '0,
  parameter prio_e             PRIO      = PRIO_RST_FIRST
) (
  input  logic [WIDTH-1:0] cur_q,
  input  logic [WIDTH-1:0] d,
  input  ctl_s             ctl,
  output logic [WIDTH-1:0] nxt_q
);

  generate
    if (PRIO == PRIO_RST_FIRST) begin : g_rst_first
      // Reset is checked before the enable.
      always_comb begin
        nxt_q = cur_q;
        if (ctl.rst) begin
          nxt_q = RST_VALUE;
        end else if (ctl.en) begin
          nxt_q = d;
        end
      end
    end else begin : g_en_first
      // Enable gates everything, reset included.
      always_comb begin
        nxt_q = cur_q;
        if (ctl.en) begin
          if (ctl.rst) begin
            nxt_q = RST_VALUE;
          end else begin
            nxt_q = d;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sreg_prio_store.sv
module sreg_prio_store #(
  parameter int WIDTH   = 8,
  parameter bit CLK_POL = 1'b1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] nxt_q,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;

  generate
    if (CLK_POL) begin : g_rise
      always_ff @(posedge clk) begin
        q_r <= nxt_q;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        q_r <= nxt_q;
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/sreg_prio.sv
module sreg_prio
  import sreg_prio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter prio_e            PRIO      = PRIO_RST_FIRST,
  parameter bit               CLK_POL   = 1'b1,
  parameter bit               RST_POL   = 1'b1,
  parameter bit               EN_POL    = 1'b1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  input  logic             srst,
  input  logic             en,
  output logic [WIDTH-1:0] q
);

  ctl_s             ctl;
  logic [WIDTH-1:0] nxt_q;
  logic [WIDTH-1:0] q_int;

  sreg_prio_ctl #(
    .RST_POL (RST_POL),
    .EN_POL  (EN_POL)
  ) u_ctl (
    .srst_pin (srst),
    .en_pin   (en),
    .ctl      (ctl)
  );

  sreg_prio_next #(
    .WIDTH     (WIDTH),
    .RST_VALUE (RST_VALUE),
    .PRIO      (PRIO)
  ) u_next (
    .cur_q (q_int),
    .d     (d),
    .ctl   (ctl),
    .nxt_q (nxt_q)
  );

  sreg_prio_store #(
    .WIDTH   (WIDTH),
    .CLK_POL (CLK_POL)
  ) u_store (
    .clk   (clk),
    .nxt_q (nxt_q),
    .q     (q_int)
  );

  assign q = q_int;

endmodule

// File: rtl/sreg_prio_chk.sv
module sreg_prio_chk
  import sreg_prio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter prio_e            PRIO      = PRIO_RST_FIRST,
  parameter bit               CLK_POL   = 1'b1,
  parameter bit               RST_POL   = 1'b1,
  parameter bit               EN_POL    = 1'b1
) (
  input logic             clk,
  input logic [WIDTH-1:0] d,
  input logic             srst,
  input logic             en,
  input logic [WIDTH-1:0] q
);

  logic cap_clk;
  logic rst_on;
  logic en_on;
  logic armed = 1'b0;

  assign cap_clk = CLK_POL ? clk : ~clk;
  assign rst_on  = (srst == RST_POL);   // R7
  assign en_on   = (en == EN_POL);      // R8

  // Q is defined once a reset has actually taken effect.
  always_ff @(posedge cap_clk) begin
    if (rst_on && (en_on || PRIO == PRIO_RST_FIRST)) armed <= 1'b1;
  end

  assert_load_R2: assert property (@(posedge cap_clk) disable iff (!armed)
    (!rst_on && en_on) |=> (q == $past(d)));

  assert_hold_R3: assert property (@(posedge cap_clk) disable iff (!armed)
    (!rst_on && !en_on) |=> $stable(q));

  assert_both_R5: assert property (@(posedge cap_clk) disable iff (!armed)
    (rst_on && en_on) |=> (q == RST_VALUE));

  generate
    if (PRIO == PRIO_RST_FIRST) begin : g_chk_rst_first
      assert_rst_wins_R4: assert property (@(posedge cap_clk) disable iff (!armed)
        (rst_on && !en_on) |=> (q == RST_VALUE));
    end else begin : g_chk_en_first
      assert_en_gates_R6: assert property (@(posedge cap_clk) disable iff (!armed)
        (rst_on && !en_on) |=> $stable(q));
    end
  endgenerate

endmodule

bind sreg_prio sreg_prio_chk #(
  .WIDTH     (WIDTH),
  .RST_VALUE (RST_VALUE),
  .PRIO      (PRIO),
  .CLK_POL   (CLK_POL),
  .RST_POL   (RST_POL),
  .EN_POL    (EN_POL)
) u_chk (
  .clk  (clk),
  .d    (d),
  .srst (srst),
  .en   (en),
  .q    (q)
);

// File: tb/sreg_prio_test.sv
module sreg_prio_test;
  import sreg_prio_pkg::*;

  localparam int         W    = 4;
  localparam logic [3:0] RV_A = 4'hA;
  localparam logic [3:0] RV_B = 4'h5;

  logic       clk = 1'b0;
  logic [3:0] a_d = '0;
  logic       a_r = 1'b0;
  logic       a_e = 1'b0;
  logic [3:0] qa;
  logic [3:0] b_d = '0;
  logic       b_r = 1'b1;
  logic       b_e = 1'b1;
  logic [3:0] qb;

  logic [3:0] exp_a = 'x;
  logic [3:0] exp_b = 'x;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  // Rising edge, active-high controls, reset-first.
  sreg_prio #(
    .WIDTH (W), .RST_VALUE (RV_A), .PRIO (PRIO_RST_FIRST),
    .CLK_POL (1'b1), .RST_POL (1'b1), .EN_POL (1'b1)
  ) uut (
    .clk (clk), .d (a_d), .srst (a_r), .en (a_e), .q (qa)
  );

  // Falling edge, active-low controls, enable-first.
  sreg_prio #(
    .WIDTH (W), .RST_VALUE (RV_B), .PRIO (PRIO_EN_FIRST),
    .CLK_POL (1'b0), .RST_POL (1'b0), .EN_POL (1'b0)
  ) uut_alt (
    .clk (clk), .d (b_d), .srst (b_r), .en (b_e), .q (qb)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called 2 ns after a rising edge.
  task automatic step_a(input logic [3:0] d, input bit ra, input bit ea, input string tag);
    a_d = d; a_r = ra; a_e = ea;
    @(negedge clk); #2;
    if (!$isunknown(exp_a)) check({tag, " R1 off-edge A"}, qa, exp_a);
    if (ra) exp_a = RV_A;
    else if (ea) exp_a = d;
    @(posedge clk); #2;
    check({tag, " A"}, qa, exp_a);
  endtask

  // Called 2 ns after a falling edge; pins are active-low.
  task automatic step_b(input logic [3:0] d, input bit ra, input bit ea, input string tag);
    b_d = d; b_r = ~ra; b_e = ~ea;
    @(posedge clk); #2;
    if (!$isunknown(exp_b)) check({tag, " R1 off-edge B"}, qb, exp_b);
    if (ea) exp_b = ra ? RV_B : d;
    @(negedge clk); #2;
    check({tag, " R7 R8 B"}, qb, exp_b);
  endtask

  function automatic string tag_of(input int c, input bit en_first);
    case (c)
      0:       return "R2 load";
      1:       return "R3 hold";
      2:       return en_first ? "R6 rst-no-en" : "R4 rst-no-en R9";
      default: return "R5 rst+en R9";
    endcase
  endfunction

  initial begin
    // Reset-first instance.
    @(posedge clk); #2;
    step_a(4'h3, 1'b1, 1'b1, "R5 reset state R9");
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 4; c++) begin
        step_a(v[3:0], (c >= 2), (c == 0 || c == 3), tag_of(c, 1'b0));
      end
    end
    a_r = 1'b0; a_e = 1'b0;

    // Enable-first instance.
    @(negedge clk); #2;
    step_b(4'hC, 1'b1, 1'b1, "R5 reset state R9");
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 4; c++) begin
        step_b(v[3:0], (c >= 2), (c == 0 || c == 3), tag_of(c, 1'b1));
      end
    end

    // Reset-first instance held still while the other ran.
    check("R3 idle A", qa, exp_a);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule